// File: doc/BRIEF.md
# DDR Write Turnaround Scheduler

This block takes memory requests (write, read or precharge) from a controller's queue and places them on the DDR SDRAM command pins. A write goes to a row that is already open. The block drives the four active-low command strobes, the bank address and the starting column, and keeps the clock-enable pin high. Its main job is timing after a write. It keeps track of when the write data window ends and holds off any command that would come too soon. While it holds off, it drives a deselect (NOP) on the pins.

The window after a write has two parts. First come tDQSS cycles. Then come burst-length/2 cycles of data transfer. A read may issue only once the write-to-read gap has run out, and a precharge only once the write-recovery gap has run out. Both gaps start at the end of the window, and each has its own counter. The requester can set a truncate flag on a read or precharge. The command may then issue as soon as the tDQSS blackout is over. The data-mask output is then held high over the rest of the write window, so the beats that were cut off are not written.

A write with auto-precharge closes its row by itself. If a later single-bank precharge arrives for that bank, it is accepted at once and nothing goes on the pins. Each request is accepted in the first cycle its timing allows. The pins show the command one clock after the accepting edge.

Top module: `wr_turn_sched`

## Requirements
- R1: A write drives cs_n=0, ras_n=1, cas_n=0, we_n=0. It puts the request bank on ba, the column on addr[COL_W-1:0] and the auto-precharge flag on addr[AP_BIT] (bit 8 by default). All other address bits are zero.
- R2: A read drives cs_n=0, ras_n=1, cas_n=0, we_n=1, with the same bank and column placement as a write. A precharge drives cs_n=0, ras_n=0, cas_n=1, we_n=0, with ba set to the bank and addr[AP_BIT] set to the all-banks flag.
- R3: After reset, and in every cycle where no command issues, cmd_valid is 0 and all four strobes are 1 (NOP). cke is always 1 and dm is 0 after reset.
- R4: A write is not accepted until BL/2 accepting edges have passed since the previous write.
- R5: A read without truncation is not accepted until TDQSS + BL/2 + TWTR edges have passed since the last write.
- R6: A precharge without truncation is not accepted until TDQSS + BL/2 + TWR edges have passed since the last write.
- R7: A read or precharge with the truncate flag is accepted once more than TDQSS edges have passed since the last write. Earlier than that, only writes go out.
- R8: A truncated read or precharge that issues inside the write window sets dm high from the next cycle. dm stays high until TDQSS + BL/2 edges have passed since the write, and a later write clears it.
- R9: After a write with auto-precharge, a single-bank precharge (all-banks flag 0) to that bank is accepted at once and issues no command. A precharge to all banks is always timed and issued.
- R10: Operation code 3 is accepted at once and issues nothing. The operation codes are 0 write, 1 read, 2 precharge.
- R11: A request is accepted at the first edge its timing rule allows. After reset, every request is allowed at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_op | input | 2 | 0 write, 1 read, 2 precharge, 3 discard |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_trunc | input | 1 | Cut the running write burst short |
| req_autopre | input | 1 | Auto-precharge flag for write/read |
| req_all | input | 1 | Precharge all banks |
| cmd_valid | output | 1 | A command is on the pins this cycle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dm | output | 1 | Data mask for the dropped write beats |

## Verification
The bench places each read and precharge exactly at the edge where its gap runs out. A design that started the gap at the write command, or that mixed up the two gaps, would then accept a request at the wrong edge. It also sends truncated commands right after the tDQSS blackout and checks that dm rises and later falls. A design that ignored the flag would stall, and one that never cleared the mask would corrupt later writes. It sends precharges to banks with auto-precharge pending, with and without the all-banks flag, to catch a scheduler that puts a needless precharge on the pins or swallows a needed one. A reset in the middle of a burst must make a read legal at once.

// File: rtl/wts_pkg.sv
package wts_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_PRE   = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP   = 4'b1111;
  localparam pins_t PINS_WRITE = 4'b0100;
  localparam pins_t PINS_READ  = 4'b0101;
  localparam pins_t PINS_PRE   = 4'b0010;
endpackage

// File: rtl/wts_burst_age.sv
// Tracks edges since the most recent write, saturating at the end of the data window.
module wts_burst_age #(
  parameter int unsigned HALF_BL = 4,
  parameter int unsigned TDQSS   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  output logic ww_ok,
  output logic early_ok,
  output logic win_done,
  output logic gap_load,
  output logic win_open_nxt
);
  localparam int unsigned WIN = TDQSS + HALF_BL;
  localparam int unsigned AW  = $clog2(WIN + 1);

  logic [AW-1:0] age_q, age_d;

  always_comb begin
    if (wr_fire)
      age_d = AW'(1);
    else if (age_q < AW'(WIN))
      age_d = age_q + 1'b1;
    else
      age_d = age_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= AW'(WIN);
    else        age_q <= age_d;
  end

  assign ww_ok        = age_q >= AW'(HALF_BL);
  assign early_ok     = age_q > AW'(TDQSS);
  assign win_done     = age_q == AW'(WIN);
  assign gap_load     = (age_d == AW'(WIN)) && (age_q != AW'(WIN));
  assign win_open_nxt = age_d < AW'(WIN);
endmodule

// File: rtl/wts_gap_timer.sv
// Down-counter armed when the last write beat is latched.
module wts_gap_timer #(
  parameter int unsigned GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic win_done,
  output logic ok
);
  localparam int unsigned CW = (GAP > 0) ? $clog2(GAP + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)
      cnt_d = CW'(GAP);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok = win_done && (cnt_q == '0);
endmodule

// File: rtl/wts_cmd_enc.sv
// Maps an operation onto strobe levels and the address bus.
module wts_cmd_enc
  import wts_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned AP_BIT = 8
) (
  input  op_e               op,
  input  logic              issue,
  input  logic [COL_W-1:0]  col,
  input  logic              ap_flag,
  output pins_t             pins,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    pins = PINS_NOP;
    addr = '0;
    if (issue) begin
      unique case (op)
        OP_WRITE: begin
          pins = PINS_WRITE;
          addr[COL_W-1:0] = col;
          addr[AP_BIT] = ap_flag;
        end
        OP_READ: begin
          pins = PINS_READ;
          addr[COL_W-1:0] = col;
          addr[AP_BIT] = ap_flag;
        end
        OP_PRE: begin
          pins = PINS_PRE;
          addr[AP_BIT] = ap_flag;
        end
        default: begin
          pins = PINS_NOP;
        end
      endcase
    end
  end
endmodule

// File: rtl/wr_turn_sched.sv
module wr_turn_sched
  import wts_pkg::*;
#(
  parameter int unsigned BL     = 8,
  parameter int unsigned TDQSS  = 1,
  parameter int unsigned TWTR   = 2,
  parameter int unsigned TWR    = 3,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned AP_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_trunc,
  input  logic              req_autopre,
  input  logic              req_all,
  output logic              cmd_valid,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dm
);
  localparam int unsigned HALF_BL = BL / 2;
  localparam int unsigned NBANK   = 1 << BA_W;

  op_e  op;
  logic ww_ok, early_ok, win_done, gap_load, win_open_nxt;
  logic [1:0] gap_ok;              // [0] write-to-read, [1] write recovery
  logic pend_hit, allowed, fire, issue, wr_fire, tr_fire;
  logic [NBANK-1:0] pend_q, pend_d;
  logic dm_q, dm_d, cmd_valid_q;
  pins_t enc_pins, pins_q;
  logic [ADDR_W-1:0] enc_addr, addr_q;
  logic [BA_W-1:0] ba_q;

  assign op = op_e'(req_op);

  wts_burst_age #(.HALF_BL(HALF_BL), .TDQSS(TDQSS)) u_age (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .ww_ok(ww_ok), .early_ok(early_ok), .win_done(win_done),
    .gap_load(gap_load), .win_open_nxt(win_open_nxt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_gap
    wts_gap_timer #(.GAP(g == 0 ? TWTR : TWR)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(gap_load),
      .win_done(win_done), .ok(gap_ok[g])
    );
  end

  // Admission rule per operation
  always_comb begin
    pend_hit = (op == OP_PRE) && !req_all && pend_q[req_bank];
    unique case (op)
      OP_WRITE: allowed = ww_ok;
      OP_READ:  allowed = gap_ok[0] || (req_trunc && early_ok);
      OP_PRE:   allowed = pend_hit || gap_ok[1] || (req_trunc && early_ok);
      default:  allowed = 1'b1;
    endcase
  end

  assign req_ready = allowed;
  assign fire      = req_valid && allowed;
  assign issue     = fire && (op != OP_NONE) && !pend_hit;
  assign wr_fire   = fire && (op == OP_WRITE);
  assign tr_fire   = issue && req_trunc && ((op == OP_READ) || (op == OP_PRE));

  wts_cmd_enc #(.COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_enc (
    .op(op), .issue(issue), .col(req_col),
    .ap_flag((op == OP_PRE) ? req_all : req_autopre),
    .pins(enc_pins), .addr(enc_addr)
  );

  // Next state: pending auto-precharge banks and data mask
  always_comb begin
    pend_d = pend_q;
    if (wr_fire)
      pend_d[req_bank] = req_autopre;
    else if (fire && (op == OP_PRE)) begin
      if (req_all) pend_d = '0;
      else         pend_d[req_bank] = 1'b0;
    end
    dm_d = !wr_fire && (dm_q || tr_fire) && win_open_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      dm_q        <= 1'b0;
      cmd_valid_q <= 1'b0;
      pins_q      <= PINS_NOP;
    end else begin
      pend_q      <= pend_d;
      dm_q        <= dm_d;
      cmd_valid_q <= issue;
      pins_q      <= enc_pins;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q   <= '0;
      addr_q <= '0;
    end else if (issue) begin
      ba_q   <= req_bank;
      addr_q <= enc_addr;
    end
  end

  assign cmd_valid = cmd_valid_q;
  assign cs_n      = pins_q.cs_n;
  assign ras_n     = pins_q.ras_n;
  assign cas_n     = pins_q.cas_n;
  assign we_n      = pins_q.we_n;
  assign cke       = 1'b1;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign dm        = dm_q;
endmodule

// File: rtl/wts_checker.sv
module wts_checker #(
  parameter int unsigned BL    = 8,
  parameter int unsigned TDQSS = 1,
  parameter int unsigned TWTR  = 2,
  parameter int unsigned TWR   = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_trunc,
  input logic cmd_valid,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dm
);
  localparam int unsigned WIN  = TDQSS + BL / 2;
  localparam int unsigned CMAX = WIN + TWTR + TWR + 1;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  logic wr_pin, rd_pin, pre_pin;
  logic [CW-1:0] since_q;

  assign wr_pin  = cmd_valid && !cs_n &&  ras_n && !cas_n && !we_n;
  assign rd_pin  = cmd_valid && !cs_n &&  ras_n && !cas_n &&  we_n;
  assign pre_pin = cmd_valid && !cs_n && !ras_n &&  cas_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_q <= CW'(CMAX);
    else if (wr_pin)            since_q <= CW'(1);
    else if (since_q < CW'(CMAX)) since_q <= since_q + 1'b1;
  end

  AST_NOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cs_n && ras_n && cas_n && we_n)); // R3

  AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin |-> (since_q >= CW'(BL / 2))); // R4

  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pin && (since_q < CW'(WIN + TWTR))) |-> (since_q > CW'(TDQSS))); // R5

  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_pin && (since_q < CW'(WIN + TWR))) |-> (since_q > CW'(TDQSS))); // R6

  AST_CMD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(req_valid && req_ready)); // R11

  AST_DM_AFTER_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dm) |-> $past(req_valid && req_ready && req_trunc)); // R8
endmodule

bind wr_turn_sched wts_checker #(.BL(BL), .TDQSS(TDQSS), .TWTR(TWTR), .TWR(TWR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_trunc(req_trunc), .cmd_valid(cmd_valid), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .dm(dm)
);

// File: tb/wr_turn_sched_bench.sv
module wr_turn_sched_bench;
  localparam int BL = 8, TDQSS = 1, TWTR = 2, TWR = 3;
  localparam int BA_W = 2, COL_W = 8, ADDR_W = 12, AP_BIT = 8;
  localparam int HB = BL / 2, WIN = TDQSS + HB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_trunc = 1'b0, req_autopre = 1'b0, req_all = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [BA_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, cmd_valid, cs_n, ras_n, cas_n, we_n, cke, dm;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  int checks = 0, errors = 0, ecnt = 0, last_w = -1000;
  logic [3:0] pend = '0;

  always #5 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  wr_turn_sched u_wr_turn_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_col(req_col), .req_trunc(req_trunc),
    .req_autopre(req_autopre), .req_all(req_all), .cmd_valid(cmd_valid),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
    .ba(ba), .addr(addr), .dm(dm)
  );

  // op, bank, col, trunc, autopre, all, idle
  localparam logic [18:0] VEC [16] = '{
    {2'd0, 2'd0, 8'h10, 1'b0, 1'b0, 1'b0, 4'd0},  // R11 first write
    {2'd0, 2'd1, 8'h20, 1'b0, 1'b0, 1'b0, 4'd0},  // R4
    {2'd1, 2'd1, 8'h21, 1'b0, 1'b0, 1'b0, 4'd0},  // R5
    {2'd2, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},  // R6
    {2'd0, 2'd2, 8'h30, 1'b0, 1'b1, 1'b0, 4'd0},  // R1 auto-precharge
    {2'd2, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},  // R9 absorbed
    {2'd1, 2'd2, 8'h31, 1'b1, 1'b0, 1'b0, 4'd0},  // R7 R8
    {2'd0, 2'd3, 8'h40, 1'b0, 1'b0, 1'b0, 4'd0},  // R4
    {2'd2, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0},  // R7 R8
    {2'd0, 2'd0, 8'h50, 1'b0, 1'b0, 1'b0, 4'd0},  // R4
    {2'd1, 2'd0, 8'h51, 1'b0, 1'b0, 1'b0, 4'd10}, // R11 late read
    {2'd3, 2'd2, 8'h77, 1'b0, 1'b0, 1'b0, 4'd0},  // R10
    {2'd2, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd0},  // R2 all banks
    {2'd0, 2'd1, 8'h60, 1'b0, 1'b1, 1'b0, 4'd0},  // R1
    {2'd2, 2'd1, 8'h00, 1'b0, 1'b0, 1'b1, 4'd0},  // R9 all banks timed
    {2'd1, 2'd1, 8'h61, 1'b0, 1'b0, 1'b0, 4'd0}   // R2 read
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pins(input logic [1:0] op);
    case (op)
      2'd0: return 4'b0100;
      2'd1: return 4'b0101;
      2'd2: return 4'b0010;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic run_req(input logic [18:0] v);
    logic [1:0] op; logic [1:0] bk; logic [7:0] col; logic tr, ap, al;
    int lim, exp_e, acc, w;
    bit absorbed, issues, exp_dm;
    logic [ADDR_W-1:0] exp_addr;
    op = v[18:17]; bk = v[16:15]; col = v[14:7]; tr = v[6]; ap = v[5]; al = v[4];
    repeat (int'(v[3:0])) @(negedge clk);
    absorbed = (op == 2'd2) && !al && pend[bk];
    issues = (op != 2'd3) && !absorbed;
    case (op)
      2'd0: lim = last_w + HB;
      2'd1: lim = last_w + (tr ? TDQSS + 1 : WIN + TWTR);
      2'd2: lim = absorbed ? 0 : last_w + (tr ? TDQSS + 1 : WIN + TWR);
      default: lim = 0;
    endcase
    exp_e = (ecnt + 1 > lim) ? ecnt + 1 : lim;
    req_op = op; req_bank = bk; req_col = col; req_trunc = tr;
    req_autopre = ap; req_all = al; req_valid = 1'b1;
    #1;
    w = 0;
    while (!req_ready && w < 200) begin
      @(negedge clk); #1; w++;
    end
    acc = ecnt + 1;
    chk(acc == exp_e, (op == 2'd0) ? "R4" : (op == 2'd1) ? (tr ? "R7" : "R5") :
        (op == 2'd2) ? (absorbed ? "R9" : tr ? "R7" : "R6") : "R10",
        "accept edge", acc, exp_e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(cmd_valid == issues, issues ? "R1" : (absorbed ? "R9" : "R10"), "cmd_valid", cmd_valid, issues);
    chk({cs_n, ras_n, cas_n, we_n} == (issues ? exp_pins(op) : 4'b1111),
        (op == 2'd0) ? "R1" : issues ? "R2" : "R3", "strobes",
        {cs_n, ras_n, cas_n, we_n}, issues ? exp_pins(op) : 4'b1111);
    if (issues) begin
      exp_addr = '0;
      if (op == 2'd2) exp_addr[AP_BIT] = al;
      else begin exp_addr[COL_W-1:0] = col; exp_addr[AP_BIT] = ap; end
      chk(addr == exp_addr && ba == bk, (op == 2'd0) ? "R1" : "R2", "addr/ba",
          {ba, addr}, {bk, exp_addr});
    end
    exp_dm = issues && tr && (op != 2'd0) && (acc - last_w + 1 < WIN);
    if (op == 2'd0) begin last_w = acc; pend[bk] = ap; end
    else if (op == 2'd2) begin
      if (al) pend = '0; else pend[bk] = 1'b0;
    end
    if (tr) begin
      chk(dm == exp_dm, "R8", "dm after truncation", dm, exp_dm);
      while (ecnt < last_w + WIN - 1) @(negedge clk);
      #1;
      chk(dm == 1'b0, "R8", "dm at window end", dm, 0);
    end else if (op == 2'd0) begin
      chk(dm == 1'b0, "R8", "dm after write", dm, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0 && dm == 1'b0, "R3", "reset cmd_valid/dm", {cmd_valid, dm}, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R3", "reset strobes",
        {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk(cke == 1'b1, "R3", "cke", cke, 1);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VEC[i]) run_req(VEC[i]);

    // Reset in the middle of a write window makes a read legal at once (R11)
    run_req({2'd0, 2'd3, 8'h0F, 1'b0, 1'b0, 1'b0, 4'd0});
    rst_n = 1'b0;
    @(negedge clk);
    chk(cmd_valid == 1'b0 && dm == 1'b0, "R3", "mid-run reset", {cmd_valid, dm}, 0);
    rst_n = 1'b1;
    last_w = -1000; pend = '0;
    req_op = 2'd1; req_bank = 2'd3; req_trunc = 1'b0; req_all = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R11", "read ready after reset", req_ready, 1);
    run_req({2'd1, 2'd3, 8'h0E, 1'b0, 1'b0, 1'b0, 4'd0});
    chk(cke == 1'b1, "R3", "cke at end", cke, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule